// File: doc/BRIEF.md
# Logarithmic PWM Dimmer

This block drives one LED channel with a pulse-width modulated signal. The brightness is an 8-bit code. A constant table, built when the design is elaborated, maps the code to a 12-bit duty count. Each step in the code scales the light output by about 0.17 dB, so equal steps in the code look like equal steps in brightness. Code zero turns the channel fully off, and the top code holds it fully on.

A free-running phase counter defines each period. It runs from 0 to 4095 and advances once per prescaler tick. With the default prescaler and a 200 MHz clock, one period lasts about 3.5 ms, which gives roughly 285 Hz. A new brightness code is taken up only when the counter wraps back to zero. A change in the middle of a period therefore never cuts a pulse short or stretches it.

The enable input gates the whole channel. While it is low, the output stays low and the counter waits at zero. When it goes high, a period starts at once with the code present at that moment.

Top module: `log_pwm_dimmer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the output is low.
- R2: Code 0 gives a duty count of 0. The output then stays low for the whole period.
- R3: Code 255 gives a duty count of 4095. The output then stays high for all 4096 counts of the period.
- R4: For codes 1 to 254, the number of high counts in a period equals round(4095 × 10^(−(255 − code) × 0.017 / 2)), with a tolerance of one count and a floor of 1. Each count lasts PRESCALE clock cycles.
- R5: In steady operation, a period lasts exactly 4096 × PRESCALE clock cycles. Each high pulse starts at phase 0 of the period.
- R6: A code change during a period has no effect on that period. The new code applies from the next wrap of the counter to zero.
- R7: While the enable is low, the output is low and the counter is held at phase 0. On the first clock edge with the enable high, a period begins, using the code present at that edge.
- R8: The phase counter advances exactly once every PRESCALE clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Channel enable; low forces the output off |
| code_i | input | 8 | Brightness code, logarithmic scale |
| pwm_o | output | 1 | PWM output to the LED driver |

## Verification
The bench measures the high time over whole periods at both ends of the scale and at random codes in between.

- **Top code:** a design that used a plain compare at code 255 would leave a one-count low gap in each period.
- **Code zero:** a design without a zero entry in the table would leak a short pulse.
- **Mid-pulse change:** the bench changes the code to full-on in the middle of a pulse. A design that took the code at once would stretch that pulse instead of letting it end at the old length.
- **Enable:** the bench checks that the output stays dark while disabled and starts at once when enabled.
- **Prescaler:** a second instance with a prescaler of 3 checks the period length and the scaled high time. An off-by-one in the tick divider would show up there.

// File: rtl/plog_pkg.sv
package plog_pkg;

    localparam int CODE_W   = 8;
    localparam int DUTY_W   = 12;
    localparam int NCODES   = 1 << CODE_W;
    localparam int FULL_CNT = (1 << DUTY_W) - 1;

    // Fixed-point attenuation of one 0.17 dB step: 10^(-0.0085) scaled by 2^24
    localparam int          FRAC_W   = 24;
    localparam longint unsigned STEP_MUL = 64'd16452045;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DUTY_W-1:0] duty_t;

    typedef struct packed {
        duty_t phase;   // position inside the current period
        duty_t level;   // duty count in force for this period
    } period_t;

    function automatic int unsigned log_duty(input int unsigned code);
        longint unsigned acc;
        longint unsigned rnd;
        if (code == 0) return 0;
        if (code >= NCODES - 1) return FULL_CNT;
        acc = longint'(FULL_CNT) << FRAC_W;
        for (int unsigned i = 0; i < (NCODES - 1) - code; i++)
            acc = (acc * STEP_MUL) >> FRAC_W;
        rnd = (acc + (64'd1 << (FRAC_W - 1))) >> FRAC_W;
        if (rnd < 1) rnd = 1;
        return int'(rnd);
    endfunction

endpackage

// File: rtl/plog_tick.sv
module plog_tick #(
    parameter int PRESCALE = 171
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int DIV_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);

    logic [DIV_W-1:0] div_q;

    assign tick_o = run_i && (div_q == DIV_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i)
            div_q <= '0;
        else if (tick_o)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    generate
        if (PRESCALE > 1) begin : g_spaced
            // R8
            tick_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/plog_curve.sv
module plog_curve
    import plog_pkg::*;
(
    input  code_t code_i,
    output duty_t duty_o
);
    duty_t table_w [NCODES];

    generate
        for (genvar g = 0; g < NCODES; g++) begin : g_entry
            assign table_w[g] = DUTY_W'(log_duty(g));
        end
    endgenerate

    assign duty_o = table_w[code_i];

endmodule

// File: rtl/plog_period.sv
module plog_period
    import plog_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    run_i,
    input  logic    tick_i,
    input  duty_t   next_duty_i,
    output period_t state_o
);
    localparam duty_t LAST = duty_t'(FULL_CNT);

    period_t st_q;
    logic    wrap;

    assign wrap    = tick_i && (st_q.phase == LAST);
    assign state_o = st_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else if (!run_i) begin
            st_q.phase <= '0;
            st_q.level <= next_duty_i;
        end else if (wrap) begin
            st_q.phase <= '0;
            st_q.level <= next_duty_i;
        end else if (tick_i) begin
            st_q.phase <= st_q.phase + 1'b1;
        end
    end

    // R6
    level_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i && !wrap |=> $stable(st_q.level));

    // R8
    phase_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i && !tick_i |=> $stable(st_q.phase));

    // R7
    idle_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> st_q.phase == '0);

endmodule

// File: rtl/log_pwm_dimmer.sv
module log_pwm_dimmer #(
    parameter int PRESCALE = 171
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic [7:0] code_i,
    output logic       pwm_o
);
    import plog_pkg::*;

    localparam duty_t LAST = duty_t'(FULL_CNT);

    logic    tick;
    duty_t   table_duty;
    period_t st;
    logic    pwm_q;

    plog_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (en_i),
        .tick_o (tick)
    );

    plog_curve u_curve (
        .code_i (code_i),
        .duty_o (table_duty)
    );

    plog_period u_period (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .run_i       (en_i),
        .tick_i      (tick),
        .next_duty_i (table_duty),
        .state_o     (st)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)
            pwm_q <= 1'b0;
        else
            pwm_q <= en_i && ((st.level == LAST) || (st.phase < st.level));
    end

    assign pwm_o = pwm_q;

    // R2
    dark_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st.level == '0 |=> !pwm_o);

    // R3
    full_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i && st.level == LAST |=> pwm_o);

    // R7
    gated_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> !pwm_o);

endmodule

// File: tb/sim_log_pwm_dimmer.sv
`timescale 1ns/1ps
module sim_log_pwm_dimmer;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [7:0] code;
    logic       p0, p1;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    log_pwm_dimmer #(.PRESCALE(1)) u0 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .code_i(code), .pwm_o(p0));

    log_pwm_dimmer #(.PRESCALE(3)) u1 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .code_i(code), .pwm_o(p1));

    function automatic int exp_duty(input int c);
        real r;
        int  v;
        if (c == 0) return 0;
        if (c == 255) return 4096;
        r = 4095.0 * (10.0 ** (-(255.0 - real'(c)) * 0.17 / 20.0));
        v = $rtoi(r + 0.5);
        if (v < 1) v = 1;
        return v;
    endfunction

    task automatic check_near(input string req, input int act, input int exp, input int tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (tol %0d)", req, act, exp, tol);
        end
    endtask

    task automatic count_high(input int which, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if ((which == 0) ? p0 : p1) hi++;
        end
    endtask

    task automatic wait_rise(input int which);
        logic prev;
        logic cur;
        prev = (which == 0) ? p0 : p1;
        forever begin
            @(negedge clk);
            cur = (which == 0) ? p0 : p1;
            if (cur && !prev) break;
            prev = cur;
        end
    endtask

    task automatic measure_code(input string req, input int c);
        int hi;
        code = 8'(c);
        repeat (4112) @(negedge clk);
        count_high(0, 4096, hi);
        check_near(req, hi, exp_duty(c), (c == 0 || c == 255) ? 0 : 1);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi;
        int gap;
        int seed;
        seed = $urandom(32'd20251);
        rst  = 1'b1;
        en   = 1'b0;
        code = 8'd255;
        repeat (4) @(negedge clk);
        check_near("R1 output during reset", int'(p0), 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check_near("R1 output after reset", int'(p0), 0, 0);

        // R7: disabled with full code stays dark
        count_high(0, 4096, hi);
        check_near("R7 disabled output", hi, 0, 0);
        en = 1'b1;
        @(negedge clk);
        check_near("R7 immediate start on enable", int'(p0), 1, 0);

        // R3: full code, no gap
        count_high(0, 4096, hi);
        check_near("R3 full code high count", hi, 4096, 0);

        // R2: code zero
        measure_code("R2 zero code high count", 0);

        // R4: directed points and random codes
        measure_code("R4 code 1", 1);
        measure_code("R4 code 128", 128);
        measure_code("R4 code 254", 254);
        for (int k = 0; k < 6; k++) begin
            int c;
            c = 1 + int'($urandom % 254);
            measure_code($sformatf("R4 random code %0d", c), c);
        end

        // R6: change in mid pulse does not stretch the running pulse
        code = 8'd100;
        repeat (4112) @(negedge clk);
        wait_rise(0);
        hi = 1;
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            if (k == 10) code = 8'd255;
            if (!p0) break;
            hi++;
        end
        check_near("R6 pulse keeps old length", hi, exp_duty(100), 1);
        repeat (4112) @(negedge clk);
        count_high(0, 4096, hi);
        check_near("R6 new code after wrap", hi, 4096, 0);

        // R8 / R5: prescaled instance
        code = 8'd60;
        repeat (12300) @(negedge clk);
        count_high(1, 12288, hi);
        check_near("R8 prescaled high time", hi, 3 * exp_duty(60), 3);
        wait_rise(1);
        gap = 0;
        begin
            logic prev;
            prev = p1;
            for (int k = 0; k < 20000; k++) begin
                @(negedge clk);
                gap++;
                if (p1 && !prev) break;
                prev = p1;
            end
        end
        check_near("R5 period length", gap, 4096 * 3, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule